// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Divider Control

This block is the feedback-divider control for a fractional-N frequency synthesizer loop. An external dual-modulus prescaler divides the oscillator by 16 or 17, and its output is the clock of this block. The block counts prescaler cycles and drives the modulus-control line, so that each output period spans 16·M + A oscillator cycles. It marks the end of each period with the pulse `fpPulse`, which goes to the phase comparator.

A fixed modulo-13 accumulator advances by the programmed numerator once per output period. When it wraps, the block adds one extra ÷17 prescaler cycle to the period that starts at that boundary. The long-run division ratio is therefore 16·M + A + numerator/13. Noise shaping and the prescaler itself lie outside the block.

The programmed values (`mainIn`, `swallowIn`, `numerIn`) are sampled only at a period boundary. Software may therefore rewrite them at any time without corrupting a count in progress.

Top module: `fracn_divctl`

## Requirements
- R1: While `rstN` is low, `fpPulse`, `modSel` and `clampFlag` are all 0. The accumulator restarts from 0. The first rising clock edge after release loads the programmed values and starts the first output period.
- R2: Each output period lasts exactly M prescaler-clock cycles, where M is the `mainIn` value in force, with a legal range of 18 to 1023.
- R3: `modSel` (1 = divide by 17, 0 = divide by 16) is high for the first A_eff cycles of a period and low for the rest. Once it has dropped within a period, it does not rise again in that period.
- R4: `fpPulse` is high for exactly one prescaler-clock cycle per period, namely the last cycle of that period.
- R5: At each period start, the accumulator adds the numerator modulo 13. If the sum reaches 13 or more, a carry occurs, and A_eff is `swallowIn` + 1 for that period. Over 13 periods, the number of extra ÷17 cycles equals the numerator.
- R6: A `numerIn` value of 13 to 15 is treated as 12. `clampFlag` is 1 for each period whose numerator was clamped and 0 otherwise.
- R7: A change on `mainIn`, `swallowIn` or `numerIn` during a period has no effect on that period. It applies from the next period on.
- R8: With A = 0 and no carry, `modSel` stays low for the whole period. With A = 15 and a carry, it is high for 16 cycles.
- R9: A numerator of 0 never produces a carry, so every period holds exactly A ÷17 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided clock from the dual-modulus prescaler |
| rstN | input | 1 | Asynchronous reset, active low |
| swallowIn | input | 4 | Programmed swallow count A |
| mainIn | input | 10 | Programmed main count M |
| numerIn | input | 4 | Programmed fractional numerator |
| modSel | output | 1 | Modulus control: 1 selects divide by 17 |
| fpPulse | output | 1 | One-cycle end-of-period pulse to the phase comparator |
| clampFlag | output | 1 | Numerator of the current period was clamped to 12 |

## Verification
The bench builds the block with its default widths: a 4-bit swallow count, a 10-bit main count, a 4-bit numerator and modulus 13. These widths let it reach the smallest legal main count of 18 and the largest effective swallow of 16, which comes from A = 15 plus a carry. They also cover the full numerator range, including the clamped codes 13 to 15. Main counts between 18 and 40 keep a full 13-period fractional cycle short, so the bench can compare every period's ÷17 count against an independent accumulator model and confirm that the total carries over those 13 periods equal the numerator.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int SWALLOW_W = 4;
  localparam int MAIN_W    = 10;
  localparam int NUMER_W   = 4;
  localparam int FRAC_MOD  = 13;

  typedef struct packed {
    logic load;       // period boundary: capture programmed values
    logic periodEnd;  // last prescaler cycle of the running period
  } divStrobe_t;
endpackage

// File: rtl/fracn_ctl.sv
module fracn_ctl
  import fracn_pkg::*;
#(
  parameter int MW = MAIN_W,
  parameter int AW = SWALLOW_W + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [MW-1:0] mActive,
  input  logic [AW-1:0] aActive,
  output divStrobe_t    strb,
  output logic          modSel,
  output logic          fpPulse,
  output logic          primed
);
  logic [MW-1:0] cnt;
  logic          primedQ;
  logic          lastCyc;

  assign lastCyc        = primedQ && (cnt == mActive - MW'(1));
  assign strb.periodEnd = lastCyc;
  assign strb.load      = !primedQ || lastCyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      primedQ <= 1'b0;
    end else if (strb.load) begin
      cnt     <= '0;
      primedQ <= 1'b1;
    end else begin
      cnt <= cnt + MW'(1);
    end
  end

  assign modSel  = primedQ && (cnt < MW'(aActive));
  assign fpPulse = lastCyc;
  assign primed  = primedQ;
endmodule

// File: rtl/fracn_dp.sv
module fracn_dp
  import fracn_pkg::*;
#(
  parameter int SW  = SWALLOW_W,
  parameter int MW  = MAIN_W,
  parameter int NW  = NUMER_W,
  parameter int MOD = FRAC_MOD
) (
  input  logic          clk,
  input  logic          rstN,
  input  divStrobe_t    strb,
  input  logic [SW-1:0] swallowIn,
  input  logic [MW-1:0] mainIn,
  input  logic [NW-1:0] numerIn,
  output logic [MW-1:0] mActive,
  output logic [SW:0]   aActive,
  output logic [NW-1:0] accVal,
  output logic          clampFlag
);
  localparam logic [NW-1:0] NUM_MAX = NW'(MOD - 1);
  localparam logic [NW:0]   MOD_V   = (NW+1)'(MOD);

  logic          overRange;
  logic [NW-1:0] numEff;
  logic [NW:0]   sum;
  logic          carry;
  logic [NW-1:0] accNext;

  assign overRange = ({1'b0, numerIn} >= MOD_V);
  assign numEff    = overRange ? NUM_MAX : numerIn;
  assign sum       = {1'b0, accVal} + {1'b0, numEff};
  assign carry     = (sum >= MOD_V);
  assign accNext   = carry ? NW'(sum - MOD_V) : NW'(sum);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mActive   <= MW'(18);
      aActive   <= '0;
      accVal    <= '0;
      clampFlag <= 1'b0;
    end else if (strb.load) begin
      mActive   <= mainIn;
      aActive   <= {1'b0, swallowIn} + (SW+1)'(carry);
      accVal    <= accNext;
      clampFlag <= overRange;
    end
  end
endmodule

// File: rtl/fracn_divctl.sv
module fracn_divctl
  import fracn_pkg::*;
#(
  parameter int SW  = SWALLOW_W,
  parameter int MW  = MAIN_W,
  parameter int NW  = NUMER_W,
  parameter int MOD = FRAC_MOD
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [SW-1:0] swallowIn,
  input  logic [MW-1:0] mainIn,
  input  logic [NW-1:0] numerIn,
  output logic          modSel,
  output logic          fpPulse,
  output logic          clampFlag
);
  divStrobe_t    strb;
  logic [MW-1:0] mActive;
  logic [SW:0]   aActive;
  logic [NW-1:0] accVal;
  logic          primed;

  fracn_ctl #(.MW(MW), .AW(SW + 1)) u_ctl (
    .clk(clk), .rstN(rstN), .mActive(mActive), .aActive(aActive),
    .strb(strb), .modSel(modSel), .fpPulse(fpPulse), .primed(primed)
  );

  fracn_dp #(.SW(SW), .MW(MW), .NW(NW), .MOD(MOD)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .swallowIn(swallowIn),
    .mainIn(mainIn), .numerIn(numerIn), .mActive(mActive),
    .aActive(aActive), .accVal(accVal), .clampFlag(clampFlag)
  );
endmodule

// File: rtl/fracn_divctl_chk.sv
module fracn_divctl_chk #(
  parameter int SW  = 4,
  parameter int MW  = 10,
  parameter int NW  = 4,
  parameter int MOD = 13
) (
  input logic          clk,
  input logic          rstN,
  input logic          modSel,
  input logic          fpPulse,
  input logic          clampFlag,
  input logic          primed,
  input logic [MW-1:0] mActive,
  input logic [SW:0]   aActive,
  input logic [NW-1:0] accVal
);
  // R4: the end pulse never lasts two cycles (main count is at least 18)
  p_fp_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    fpPulse |=> !fpPulse);

  // R3: modulus control does not re-rise inside a period
  p_mod_prefix_r3: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !modSel && !fpPulse) |=> !modSel);

  // R7: active main and swallow values hold inside a period
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !fpPulse) |=> ($stable(mActive) && $stable(aActive)));

  // R6: the clamp flag changes only at a period boundary
  p_clamp_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !fpPulse) |=> $stable(clampFlag));

  // R5: the accumulator stays below the modulus
  p_acc_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    accVal < NW'(MOD));

  // R8: the effective swallow never exceeds the swallow range plus one carry
  p_swallow_max_r8: assert property (@(posedge clk) disable iff (!rstN)
    aActive <= (SW+1)'(1 << SW));
endmodule

bind fracn_divctl fracn_divctl_chk #(.SW(SW), .MW(MW), .NW(NW), .MOD(MOD)) u_chk (
  .clk(clk), .rstN(rstN), .modSel(modSel), .fpPulse(fpPulse),
  .clampFlag(clampFlag), .primed(primed), .mActive(mActive),
  .aActive(aActive), .accVal(accVal)
);

// File: tb/sim_fracn_divctl.sv
`timescale 1ns/1ps
module sim_fracn_divctl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] swallowIn = '0;
  logic [9:0] mainIn = 10'd20;
  logic [3:0] numerIn = '0;
  logic       modSel, fpPulse, clampFlag;

  int nChecks = 0;
  int nBad = 0;
  bit done = 1'b0;
  int accModel;

  always #10 clk = ~clk;

  fracn_divctl u0 (
    .clk(clk), .rstN(rstN), .swallowIn(swallowIn), .mainIn(mainIn),
    .numerIn(numerIn), .modSel(modSel), .fpPulse(fpPulse), .clampFlag(clampFlag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reset, program, release; the next negedge is the first cycle of period 1.
  task automatic startDut(input int m, input int a, input int n);
    @(negedge clk);
    rstN = 1'b0;
    mainIn = 10'(m); swallowIn = 4'(a); numerIn = 4'(n);
    accModel = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Expected ÷17 count for the next period from the model (numerator clamped).
  function automatic int nextHigh(input int a, input int n);
    int ne = (n >= 13) ? 12 : n;
    accModel += ne;
    if (accModel >= 13) begin
      accModel -= 13;
      return a + 1;
    end
    return a;
  endfunction

  // Measure one period; optional mid-period reprogramming after chgAt cycles.
  task automatic runPeriod(input int chgAt, input int nm, input int na, input int nn,
                           output int len, output int hi, output int fpCnt,
                           output int fpLast, output int reRise);
    bit seenLow = 1'b0;
    len = 0; hi = 0; fpCnt = 0; fpLast = 0; reRise = 0;
    for (int i = 0; i < 1100; i++) begin
      @(negedge clk);
      len++;
      if (modSel) begin
        hi++;
        if (seenLow) reRise++;
      end else seenLow = 1'b1;
      if (fpPulse) fpCnt++;
      if (len == chgAt) begin
        mainIn = 10'(nm); swallowIn = 4'(na); numerIn = 4'(nn);
      end
      if (fpPulse) begin
        fpLast = 1;
        break;
      end
    end
  endtask

  task automatic tReset();
    @(negedge clk);
    rstN = 1'b0;
    numerIn = 4'd15; swallowIn = 4'd7;
    repeat (3) @(negedge clk);
    check(fpPulse == 1'b0, "R1 fp in reset", fpPulse, 0);
    check(modSel == 1'b0, "R1 modSel in reset", modSel, 0);
    check(clampFlag == 1'b0, "R1 clampFlag in reset", clampFlag, 0);
  endtask

  task automatic tInteger();
    int len, hi, fc, fl, rr;
    startDut(20, 5, 0);
    for (int p = 0; p < 3; p++) begin
      runPeriod(-1, 0, 0, 0, len, hi, fc, fl, rr);
      check(len == 20, "R2 period length", len, 20);
      check(hi == 5, "R9 no carry with zero numerator", hi, 5);
      check(fc == 1 && fl == 1, "R4 single fp at end", fc, 1);
      check(rr == 0, "R3 modSel prefix", rr, 0);
    end
  endtask

  task automatic tZeroSwallow();
    int len, hi, fc, fl, rr;
    startDut(18, 0, 0);
    runPeriod(-1, 0, 0, 0, len, hi, fc, fl, rr);
    check(len == 18, "R2 minimum main count", len, 18);
    check(hi == 0, "R8 zero swallow", hi, 0);
  endtask

  task automatic tFraction(input int m, input int a, input int n, input string tag);
    int len, hi, fc, fl, rr, exp, extra;
    extra = 0;
    startDut(m, a, n);
    for (int p = 0; p < 13; p++) begin
      exp = nextHigh(a, n);
      runPeriod(-1, 0, 0, 0, len, hi, fc, fl, rr);
      check(hi == exp, {tag, " per-period swallow"}, hi, exp);
      check(len == m, "R2 period length fractional", len, m);
      extra += hi - a;
    end
    exp = (n >= 13) ? 12 : n;
    check(extra == exp, "R5 carries over 13 periods", extra, exp);
  endtask

  task automatic tMaxCarry();
    int len, hi, fc, fl, rr, exp;
    bit saw16 = 1'b0;
    startDut(40, 15, 12);
    for (int p = 0; p < 4; p++) begin
      exp = nextHigh(15, 12);
      runPeriod(-1, 0, 0, 0, len, hi, fc, fl, rr);
      check(hi == exp, "R8 swallow with carry", hi, exp);
      if (hi == 16) saw16 = 1'b1;
    end
    check(saw16, "R8 sixteen divide-by-17 cycles seen", saw16, 1);
  endtask

  task automatic tClamp();
    int len, hi, fc, fl, rr, exp;
    startDut(22, 2, 15);
    exp = nextHigh(2, 15);
    runPeriod(-1, 0, 0, 0, len, hi, fc, fl, rr);
    check(clampFlag == 1'b0 || clampFlag == 1'b1, "R6 flag defined", clampFlag, 1);
    check(hi == exp, "R6 clamped numerator swallow", hi, exp);
    @(negedge clk);
    check(clampFlag == 1'b1, "R6 clamp flag set", clampFlag, 1);
    startDut(22, 2, 13);
    @(negedge clk);
    check(clampFlag == 1'b1, "R6 clamp flag for 13", clampFlag, 1);
    startDut(22, 2, 4);
    @(negedge clk);
    check(clampFlag == 1'b0, "R6 clamp flag clear for 4", clampFlag, 0);
    tFraction(20, 1, 14, "R6");
  endtask

  task automatic tMidChange();
    int len, hi, fc, fl, rr;
    startDut(25, 2, 0);
    runPeriod(7, 19, 9, 12, len, hi, fc, fl, rr);
    check(len == 25, "R7 length unchanged mid-period", len, 25);
    check(hi == 2, "R7 swallow unchanged mid-period", hi, 2);
    check(clampFlag == 1'b0, "R7 flag unchanged mid-period", clampFlag, 0);
    runPeriod(-1, 0, 0, 0, len, hi, fc, fl, rr);
    check(len == 19, "R7 new length next period", len, 19);
    check(hi == 9, "R7 new swallow next period", hi, 9);
    runPeriod(-1, 0, 0, 0, len, hi, fc, fl, rr);
    check(hi == 10, "R7 new numerator carries", hi, 10);
  endtask

  initial begin
    tReset();
    tInteger();
    tZeroSwallow();
    tFraction(30, 3, 5, "R5");
    tFraction(18, 0, 1, "R5");
    tMaxCarry();
    tClamp();
    tMidChange();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end
endmodule